// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 65,536 words by 4 bits. The host hands over one word at a time through a valid/ready handshake: a read/write flag, an address and write data. The controller turns each request into a sequence of active-low strobes (chip select, write strobe, output gate) on the RAM pins. It drives the write data onto the shared data pad, with a separate pad-drive enable, and it registers the read data on the way back.

Every strobe phase lasts a whole number of clock cycles, and parameters set the lengths: the read access window, the width of the write pulse and the idle recovery after each transfer. With a 10 ns clock the defaults of two access cycles and one pulse cycle cover a 15 ns address-to-data time and a 10 ns write pulse. A recovery phase with every strobe released separates consecutive transfers. This keeps the RAM's output-disable delay and the controller's own pad drive from overlapping.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, chip select, write strobe and output gate are all high, pad drive is off, the response valid is low and the request ready is high.
- R2: A request is taken on a clock edge where request valid and request ready are both high. Ready then stays low for exactly WP_CYC+TA_CYC cycles after a write and ACC_CYC+TA_CYC cycles after a read. A request that is already waiting is taken on the first cycle ready is high again.
- R3: A write pulls chip select and write strobe low together for exactly WP_CYC cycles, starting in the cycle after the request is taken. The output gate stays high throughout.
- R4: Pad drive is on only while the write strobe is low, and during that time the data pad carries the write data of the request.
- R5: A read pulls chip select and output gate low together for exactly ACC_CYC cycles, starting in the cycle after the request is taken. The write strobe stays high throughout.
- R6: Read data is sampled on the clock edge that ends the access window. It is presented with response valid high for exactly one cycle, the cycle after that edge, and holds the word last written to that address.
- R7: The RAM address equals the address of the accepted request from the first strobe cycle until the next request is taken, so it is stable through the whole of every strobe phase.
- R8: After each transfer all strobes are high and pad drive is off for TA_CYC cycles (at least one), so the output gate never falls while pad drive is on or in the cycle right after it.
- R9: While no transfer is in progress (ready high), chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_dq_out | output | DATA_W | Value for the data pad output buffer |
| mem_dq_oe | output | 1 | Data pad output buffer enable |
| mem_dq_in | input | DATA_W | Value from the data pad input buffer |

## Verification
Two events meet at one clock edge. On the edge that ends a write, the RAM commits the word while the controller releases its pad drive. After that, the recovery phase ends in the same cycle that a waiting read request is taken. The bench raises the read request for the same address while the write is still in flight and holds it. It then checks three things: the read strobes start one cycle after ready rises, the data returned is the word just written, and the pad drive was off for the whole cycle before the output gate fell. A RAM model in the bench hands back inverted data for any sample taken before the access count has elapsed, and it measures every write pulse against the configured width.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_WRITE   = 2'd1,
    SEQ_READ    = 2'd2,
    SEQ_RECOVER = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  // Pin pattern that a sequencer phase presents to the RAM.
  function automatic strobe_t strobes_for(seq_state_e st);
    strobe_t s;
    s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (st)
      SEQ_WRITE: begin
        s.ce_n  = 1'b0;
        s.we_n  = 1'b0;
        s.drive = 1'b1;
      end
      SEQ_READ: begin
        s.ce_n = 1'b0;
        s.oe_n = 1'b0;
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/asram_reset_sync.sv
module asram_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_en) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TMR_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_val != '0) |=> !expired); // R2

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int ACC_CYC = 2,
  parameter int WP_CYC  = 1,
  parameter int TA_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output logic       capture,
  output seq_state_e state_d
);

  localparam int MAX_CYC = (ACC_CYC > WP_CYC) ?
                           ((ACC_CYC > TA_CYC) ? ACC_CYC : TA_CYC) :
                           ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

  seq_state_e       state_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  asram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = SEQ_WRITE;
            tmr_val = WP_LD;
          end else begin
            state_d = SEQ_READ;
            tmr_val = ACC_LD;
          end
        end
      end
      SEQ_WRITE, SEQ_READ: begin
        if (tmr_done) begin
          state_d  = SEQ_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = TA_LD;
        end
      end
      SEQ_RECOVER: begin
        if (tmr_done) begin
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == SEQ_READ) && tmr_done;

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == SEQ_WRITE || state_q == SEQ_READ)); // R2
  AST_IDLE_VIA_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(state_q) == SEQ_RECOVER); // R8
  AST_CAPTURE_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> state_q == SEQ_RECOVER); // R6

endmodule

// File: rtl/asram_pin_driver.sv
module asram_pin_driver
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  seq_state_e        state_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  strobe_t           strb_d;
  strobe_t           strb_q;
  logic              strb_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  always_comb begin
    strb_d  = strobes_for(state_d);
    strb_en = (strb_d != strb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    end else if (strb_en) begin
      strb_q <= strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = strb_q.ce_n;
  assign mem_we_n   = strb_q.we_n;
  assign mem_oe_n   = strb_q.oe_n;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = strb_q.drive;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_q.we_n |-> !strb_q.ce_n); // R3
  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_q.we_n |-> strb_q.oe_n); // R3
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.drive |-> !strb_q.we_n); // R4
  AST_OE_AFTER_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_q.oe_n) |-> !$past(strb_q.drive)); // R8
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |=> !rsp_q); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_q.ce_n && $past(!strb_q.ce_n)) |-> $stable(addr_q)); // R7

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 4,
  parameter int ACC_CYC = 2,
  parameter int WP_CYC  = 1,
  parameter int TA_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  logic       rst_sync_n;
  logic       accept;
  logic       capture;
  seq_state_e state_d;

  asram_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  asram_sequencer #(
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC),
    .TA_CYC  (TA_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .state_d   (state_d)
  );

  asram_pin_driver #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .capture    (capture),
    .state_d    (state_d),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  AST_READY_MEANS_STANDBY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> mem_ce_n); // R9
  AST_TAKEN_STARTS_STROBES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready) |=> (!mem_ce_n && !req_ready)); // R2
  AST_NO_PAD_FIGHT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dq_oe |-> mem_oe_n); // R8

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int AW  = 6;
  localparam int DW  = 4;
  localparam int ACC = 3;
  localparam int WP  = 2;
  localparam int TA  = 1;
  localparam int NW  = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n;
  logic          mem_we_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int n_chk;
  int n_fail;
  bit done;

  asram_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .ACC_CYC (ACC), .WP_CYC (WP), .TA_CYC (TA)
  ) u_asram_ctrl (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // RAM model: array plus strobe truth table, pulse and access timers.
  logic [DW-1:0] ram [NW];
  int  acc_run;
  int  we_run;
  bit  prev_drive;

  assign mem_dq_in = (!mem_ce_n && mem_we_n && !mem_oe_n) ?
                     ((acc_run >= ACC - 1) ? ram[mem_addr] : ~ram[mem_addr]) : '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_run    <= 0;
      we_run     <= 0;
      prev_drive <= 1'b0;
    end else begin
      prev_drive <= mem_dq_oe;
      if (!mem_ce_n && !mem_we_n) begin
        ram[mem_addr] <= mem_dq_out;
        we_run <= we_run + 1;
        if (!mem_dq_oe) begin
          n_fail++;
          $display("FAIL R4 pad drive off in write pulse actual=0 expected=1");
        end
      end else begin
        if (we_run != 0) chk(we_run == WP, "R3 write pulse width", we_run, WP);
        we_run <= 0;
      end
      if (mem_dq_oe && mem_we_n) begin
        n_fail++;
        $display("FAIL R4 pad driven outside write pulse actual=1 expected=0");
      end
      if (!mem_ce_n && !mem_oe_n) begin
        acc_run <= acc_run + 1;
        if (acc_run == 0 && prev_drive) begin
          n_fail++;
          $display("FAIL R8 output gate fell after driven cycle actual=1 expected=0");
        end
        if (!mem_we_n) begin
          n_fail++;
          $display("FAIL R5 write strobe low during read actual=0 expected=1");
        end
      end else begin
        if (acc_run != 0) chk(acc_run == ACC, "R5 access window length", acc_run, ACC);
        acc_run <= 0;
      end
    end
  end

  // Called at a falling edge; returns at the falling edge of the first strobe cycle.
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
    chk(!mem_ce_n && mem_addr == a, "R7 address with first strobe", mem_addr, a);
    if (wr) chk(!mem_we_n && mem_oe_n, "R3 write strobes start", {mem_we_n, mem_oe_n}, 1);
    else    chk(!mem_oe_n && mem_we_n, "R5 read strobes start", {mem_we_n, mem_oe_n}, 2);
  endtask

  task automatic complete(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int busy;
    int pulses;
    logic [DW-1:0] got;
    busy = 0;
    pulses = 0;
    got = '0;
    while (!req_ready) begin
      busy++;
      if (!mem_ce_n && mem_addr != a) begin
        n_fail++;
        $display("FAIL R7 address moved actual=%0d expected=%0d", mem_addr, a);
      end
      if (rsp_valid) begin
        pulses++;
        got = rsp_rdata;
      end
      @(negedge clk);
    end
    chk(busy == (wr ? WP + TA : ACC + TA), "R2 busy length", busy, wr ? WP + TA : ACC + TA);
    chk(mem_ce_n && mem_dq_oe == 1'b0, "R8 recovered bus", mem_ce_n, 1);
    if (wr) begin
      chk(pulses == 0, "R6 no response on write", pulses, 0);
    end else begin
      chk(pulses == 1, "R6 one response pulse", pulses, 1);
      chk(got == exp, "R6 read data", got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !rsp_valid, "R1 drive and response off in reset", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(mem_ce_n, "R9 standby while idle", mem_ce_n, 1);

    // Sweep 1: write every address, then read every address.
    for (int a = 0; a < NW; a++) begin
      issue(1'b1, AW'(a), DW'(a * 7 + 3));
      complete(1'b1, AW'(a), '0);
    end
    for (int a = 0; a < NW; a++) begin
      issue(1'b0, AW'(a), '0);
      complete(1'b0, AW'(a), DW'(a * 7 + 3));
    end

    // Sweep 2: each write followed by a read of the same word that waits during the write.
    for (int a = 0; a < NW; a++) begin
      issue(1'b1, AW'(a), DW'((a >> 2) ^ (a * 3) ^ 9));
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = AW'(a);
      complete(1'b1, AW'(a), '0);
      chk(req_valid && req_ready, "R2 waiting request sees ready", req_ready, 1);
      issue(1'b0, AW'(a), '0);
      complete(1'b0, AW'(a), DW'((a >> 2) ^ (a * 3) ^ 9));
    end

    // Idle: no strobe activity without a request.
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(mem_ce_n && req_ready && !rsp_valid, "R9 quiet idle", mem_ce_n, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule